// File: doc/BRIEF.md
# Speculative Stack Pointer Tracker

This block sits early in a processor front end and follows the stack pointer without waiting for the execution units. In every cycle it accepts up to four stack operations in program order, one per lane. Each lane is a push, a pop, or a small signed adjustment, and every amount is at most 16 bytes. In the same cycle the block returns the stack-pointer value that each lane's operation uses. A push reports the address after its decrement. A pop reports the value before its increment. An adjustment reports the value after it is applied. At the clock edge the committed base advances by the sum of all the lane deltas.

All four lane values are formed in parallel. The lane deltas are summed into running offsets in an 8-bit signed adder. Each offset is then added to only the low 8 bits of the base. Because an offset is never larger than 64 bytes, the upper 24 bits of the base can change by at most one. A pre-incremented copy and a pre-decremented copy of those upper bits are computed once and shared by every lane, and each lane picks one of the three upper-bit values, as a carry-select adder does. When another instruction writes the stack pointer, the sync input loads the new value as the base. In that cycle the sync takes priority over the lanes, and their deltas are thrown away.

Top module: `sp_track`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sp_base` equals `RESET_SP` (default 0x0001_0000).
- R2: A lane with kind 2'b01 (push) takes `amt` as an unsigned byte count from 0 to 16. Its `sp_lane` value is the base plus the offset of all earlier lanes, minus `amt`.
- R3: A lane with kind 2'b10 (pop) takes `amt` as an unsigned byte count from 0 to 16. Its `sp_lane` value is the base plus the offset of all earlier lanes, before the pop's own `amt` is added.
- R4: A lane with kind 2'b11 (adjust) takes `amt` as a signed count from -16 to +16. Its `sp_lane` value is the base plus the offset of earlier lanes plus its own `amt`.
- R5: Lane 0 is the oldest operation. Every lane value already includes the deltas of all lower-numbered lanes in the same cycle, and all lane values appear in the same cycle as the inputs.
- R6: A lane with kind 2'b00 (idle) drives `lane_vld` low and `sp_lane` to zero, and it does not change the base. A cycle in which every lane is idle and there is no sync leaves `sp_base` unchanged.
- R7: Without a sync, `sp_base` in the next cycle equals the current base plus the sum of all lane deltas. A push delta is -amt, a pop delta is +amt, and an adjust delta is the signed amt.
- R8: All results are exact modulo 2^32. This holds when an offset carries into or borrows from bit 8 of the base, and when the result wraps past 0 or past 0xFFFF_FFFF.
- R9: When `sync_en` is high, every `lane_vld` is low and every `sp_lane` is zero, the lane deltas of that cycle are discarded, and `sp_base` equals `sync_sp` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_en | input | 1 | Load a new base from `sync_sp` and discard this cycle's lanes |
| sync_sp | input | 32 | Stack-pointer value written by a general instruction |
| op_kind | input | 8 | Two bits per lane: 00 idle, 01 push, 10 pop, 11 adjust; lane i at bits [2i+1:2i] |
| op_amt | input | 24 | Six bits per lane, lane i at bits [6i+5:6i]; unsigned for push/pop, signed for adjust |
| sp_lane | output | 128 | Stack-pointer value used by each lane, lane i at bits [32i+31:32i] |
| lane_vld | output | 4 | Lane i carries a live operation this cycle |
| sp_base | output | 32 | Committed stack-pointer base |

## Verification
The assertions assume that a push or pop amount lies between 0 and 16 and that an adjust amount lies between -16 and +16. Under that assumption the total movement in one cycle stays within 64 bytes, and the carry-select upper bits never need to move by more than one. The stimulus keeps to this range: push and pop amounts are drawn from 0 to 16 and adjust amounts from -16 to +16. Directed cases then place the base just below or just above a 256-byte boundary, and next to zero and to the top of the address space, so the carry, borrow and wrap paths are reached with legal inputs only.

// File: rtl/sp_track.sv
module sp_track #(
  parameter int LANES    = 4,
  parameter int SPW      = 32,
  parameter int AW       = 6,
  parameter int LOW      = 8,
  parameter logic [SPW-1:0] RESET_SP = 32'h0001_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_en,
  input  logic [SPW-1:0]       sync_sp,
  input  logic [2*LANES-1:0]   op_kind,
  input  logic [AW*LANES-1:0]  op_amt,
  output logic [SPW*LANES-1:0] sp_lane,
  output logic [LANES-1:0]     lane_vld,
  output logic [SPW-1:0]       sp_base
);
  localparam int HW = SPW - LOW;
  localparam logic [1:0] K_PUSH = 2'b01;
  localparam logic [1:0] K_POP  = 2'b10;
  localparam logic [1:0] K_ADJ  = 2'b11;

  logic [SPW-1:0] base_q;
  logic [HW-1:0]  hi_up, hi_dn;
  logic signed [LOW-1:0] pre  [LANES+1];
  logic signed [LOW-1:0] seen [LANES];

  assign hi_up   = base_q[SPW-1:LOW] + HW'(1);
  assign hi_dn   = base_q[SPW-1:LOW] - HW'(1);
  assign sp_base = base_q;

  function automatic logic [SPW-1:0] csel_add(
    input logic [SPW-1:0] b,
    input logic [HW-1:0]  up,
    input logic [HW-1:0]  dn,
    input logic signed [LOW-1:0] off
  );
    logic signed [LOW+1:0] s;
    logic [HW-1:0] h;
    s = $signed({2'b00, b[LOW-1:0]}) + $signed({{2{off[LOW-1]}}, off});
    if (s[LOW+1])   h = dn;
    else if (s[LOW]) h = up;
    else            h = b[SPW-1:LOW];
    return {h, s[LOW-1:0]};
  endfunction

  always_comb begin
    pre[0] = '0;
    for (int i = 0; i < LANES; i++) begin
      logic [1:0] k;
      logic signed [LOW-1:0] a, d;
      k = op_kind[2*i +: 2];
      a = {{(LOW-AW){op_amt[AW*i+AW-1]}}, op_amt[AW*i +: AW]};
      case (k)
        K_PUSH:  begin d = -a; seen[i] = pre[i] + d; end
        K_POP:   begin d = a;  seen[i] = pre[i];     end
        K_ADJ:   begin d = a;  seen[i] = pre[i] + d; end
        default: begin d = '0; seen[i] = '0;         end
      endcase
      pre[i+1] = pre[i] + d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    wire live = !sync_en && (op_kind[2*g +: 2] != 2'b00);
    assign lane_vld[g] = live;
    assign sp_lane[SPW*g +: SPW] = live ? csel_add(base_q, hi_up, hi_dn, seen[g]) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= RESET_SP;
    else if (sync_en) base_q <= sync_sp;
    else              base_q <= csel_add(base_q, hi_up, hi_dn, pre[LANES]);
  end
endmodule

// File: rtl/sp_track_chk.sv
module sp_track_chk #(
  parameter int LANES = 4,
  parameter int SPW   = 32,
  parameter int AW    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sync_en,
  input logic [SPW-1:0]       sync_sp,
  input logic [2*LANES-1:0]   op_kind,
  input logic [AW*LANES-1:0]  op_amt,
  input logic [SPW*LANES-1:0] sp_lane,
  input logic [LANES-1:0]     lane_vld,
  input logic [SPW-1:0]       sp_base
);
  logic signed [AW-1:0] amt0;
  assign amt0 = op_amt[AW-1:0];

  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |=> sp_base == $past(sync_sp)); // R9
  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_en |-> lane_vld == '0); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && op_kind == '0) |=> $stable(sp_base)); // R6
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (sp_base - $past(sp_base) + SPW'(64)) <= SPW'(128)); // R7
  AST_PUSH_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && op_kind[1:0] == 2'b01) |-> sp_lane[SPW-1:0] == sp_base - SPW'(amt0)); // R2
  AST_POP_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && op_kind[1:0] == 2'b10) |-> sp_lane[SPW-1:0] == sp_base); // R3

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    logic signed [AW-1:0] a;
    assign a = op_amt[AW*g +: AW];
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_vld[g] |-> sp_lane[SPW*g +: SPW] == '0); // R6
    AST_AMT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind[2*g +: 2] == 2'b11) ? (a >= -16 && a <= 16)
                                   : (a >= 0 && a <= 16)); // R4
  end
endmodule

bind sp_track sp_track_chk #(.LANES(LANES), .SPW(SPW), .AW(AW)) u_chk (.*);

// File: tb/sim_sp_track.sv
`timescale 1ns/1ps
module sim_sp_track;
  localparam int L = 4;
  localparam int AW = 6;
  localparam logic [31:0] RST_SP = 32'h0001_0000;

  logic clk = 0, rst_n = 0, sync_en = 0;
  logic [31:0] sync_sp = '0;
  logic [2*L-1:0] op_kind = '0;
  logic [AW*L-1:0] op_amt = '0;
  logic [32*L-1:0] sp_lane;
  logic [L-1:0] lane_vld;
  logic [31:0] sp_base;

  int total = 0, bad = 0;
  logic [31:0] mb;
  string btag;

  sp_track u0 (.*);

  always #2.5 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(logic [2*L-1:0] k, logic [AW*L-1:0] a, logic s, logic [31:0] sv);
    logic [31:0] run, ex;
    logic signed [AW-1:0] v;
    chk({btag, " base"}, sp_base, mb);
    op_kind = k; op_amt = a; sync_en = s; sync_sp = sv;
    #1;
    run = mb;
    for (int i = 0; i < L; i++) begin
      string t;
      v = a[AW*i +: AW];
      ex = 0;
      t = "R6";
      if (s) t = "R9";
      else case (k[2*i +: 2])
        2'b01: begin run = run - 32'(v); ex = run; t = "R2/R5 push"; end
        2'b10: begin ex = run; run = run + 32'(v); t = "R3/R5 pop"; end
        2'b11: begin run = run + 32'(signed'(v)); ex = run; t = "R4/R5 adjust"; end
        default: ;
      endcase
      chk(t, sp_lane[32*i +: 32], ex);
      chk({t, " vld"}, 32'(lane_vld[i]), 32'(!s && k[2*i +: 2] != 2'b00));
    end
    mb = s ? sv : run;
    btag = s ? "R9" : "R7";
    @(negedge clk);
  endtask

  function automatic logic [AW*L-1:0] same_amt(int n);
    logic [AW*L-1:0] r;
    for (int i = 0; i < L; i++) r[AW*i +: AW] = AW'(n);
    return r;
  endfunction

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 base in reset", sp_base, RST_SP);
    rst_n = 1;
    mb = RST_SP; btag = "R1";
    // R5: four dependent pushes in one cycle
    step(8'b01010101, same_amt(4), 0, 0);
    // mix of all kinds, adjust -12
    step({2'b10, 2'b11, 2'b10, 2'b01}, {6'd4, 6'(-12), 6'd8, 6'd8}, 0, 0);
    // R6: idle lanes interleaved, then all idle
    step({2'b00, 2'b01, 2'b00, 2'b10}, {6'd9, 6'd16, 6'd7, 6'd12}, 0, 0);
    step(8'b0, same_amt(5), 0, 0);
    // R9: sync discards live lanes
    step(8'b11111111, same_amt(16), 1, 32'h0000_00F8);
    // R8: carry across bit 8
    step(8'b10101010, same_amt(16), 0, 0);
    step(8'b0, '0, 1, 32'h0000_0104);
    // R8: borrow across bit 8
    step(8'b01010101, same_amt(16), 0, 0);
    step(8'b0, '0, 1, 32'h0000_0004);
    // R8: wrap below zero
    step(8'b01010101, same_amt(8), 0, 0);
    step(8'b0, '0, 1, 32'hFFFF_FFF8);
    // R8: wrap past top
    step(8'b10101010, same_amt(16), 0, 0);
    step({2'b11, 2'b11, 2'b11, 2'b11}, same_amt(-16), 0, 0);
    for (int c = 0; c < 3000; c++) begin
      logic [2*L-1:0] k;
      logic [AW*L-1:0] a;
      k = 8'($urandom);
      for (int i = 0; i < L; i++)
        a[AW*i +: AW] = (k[2*i +: 2] == 2'b11) ? AW'($urandom_range(0, 32) - 16)
                                               : AW'($urandom_range(0, 16));
      if ($urandom_range(0, 15) == 0)
        step(k, a, 1, ($urandom_range(0, 1) != 0) ? $urandom : 32'h0000_0100 - 32'($urandom_range(0, 40)));
      else
        step(k, a, 0, 0);
    end
    chk({btag, " final base"}, sp_base, mb);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule